// File: doc/BRIEF.md
# Configurable Asynchronous Serial Engine

This block is a full-duplex asynchronous serial transmitter and receiver. A small byte-wide register write port sets the whole frame shape: 7 or 8 data bits, no parity or odd or even parity, and one or two stop bits. Two more byte writes set a 16-bit baud divisor. Each bit lasts sixteen sub-ticks. One sub-tick is `divisor + 1` clock cycles, and there is no fractional correction. A port-wide enable and a control byte gate the two engines. The control byte holds a receive-on bit, a transmit-on bit and a level-held soft reset.

Bytes to be sent arrive on a valid/ready pair and leave on `txLine`, least significant bit first, framed by a low start bit and high stop bits. Incoming frames on `rxLine` are oversampled sixteen times per bit. The receiver confirms the start bit at its middle and rejects short low pulses as glitches. It then samples every following bit at its centre. A finished character is placed in a one-entry holding register and offered on a valid/ready pair. The status byte shows the outcome of the most recent character and a transmitter-idle flag. The outcome is parity, framing or overrun, and software resolves several at once in that order.

Top module: `sio_core`

## Requirements
- R1: Register writes use `regAddr` 0 (port enable, bit 0), 1 (control), 2 (frame format), 3 (divisor bits 7:0) and 4 (divisor bits 15:8). After reset the port is disabled, control is 0, the format is 8 data bits / no parity / one stop bit and the divisor is 0.
- R2: Format bit 0 set gives 8 data bits and clear gives 7. A transmitted frame is a low start bit, then the data bits least significant first. A 7-bit received character reads back with bit 7 zero.
- R3: Format bit 1 set sends two high stop bits and clear sends one. The receiver checks only the first stop bit.
- R4: Format bit 2 inserts a parity bit after the data. Format bit 4 set makes the total count of ones (data plus parity) odd, and clear makes it even.
- R5: One bit lasts 16 × (divisor + 1) clock cycles on both transmit and receive.
- R6: A low level on `rxLine` that is gone by the middle of the would-be start bit produces no character. The receiver then accepts the next real frame.
- R7: Status bit 0 is set for a received character whose parity bit disagrees with the configured mode. The character is still delivered.
- R8: Status bit 1 is set when `rxLine` is low at the middle of the first stop bit. The character is still delivered.
- R9: Status bit 2 is set when a character completes while the previous one is still held unaccepted. The new character is dropped and the held one stays on `rxData`.
- R10: Status bit 6 is 1 exactly when the transmitter has no frame in progress. The line is then high. Status bits 3, 4, 5 and 7 read 0.
- R11: Control bit 0 enables reception and bit 1 enables transmission. With bit 0 clear, line activity yields no character. With bit 1 clear, `txReady` stays low.
- R12: Control bit 2 held set returns both engines to idle, empties the holding register and clears status bits 2:0.
- R13: With enable bit 0 clear, both engines are held idle and `txReady` is low.
- R14: Status bits 2:0 describe only the latest completed character. A clean character clears earlier error flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 8 | Register write data |
| txValid | input | 1 | Byte offered for transmission |
| txData | input | 8 | Byte to transmit |
| txReady | output | 1 | Transmitter accepts `txData` this cycle |
| txLine | output | 1 | Serial output, idle high |
| rxLine | input | 1 | Serial input, idle high |
| rxData | output | 8 | Held received character |
| rxValid | output | 1 | Holding register full |
| rxReady | input | 1 | Consumer takes the held character |
| statusOut | output | 8 | Bit 0 parity, 1 framing, 2 overrun, 6 transmitter idle |

## Verification
The properties assume that `rxReady` and the register port follow ordinary handshake rules. A held character is only released by `rxReady` or by an engine-clearing write. Register writes are single-cycle strobes sampled at the clock. The stimulus drives every input on the falling clock edge. It changes `rxLine` only at whole-bit intervals computed from the programmed divisor, except in the deliberate glitch and short-stop cases. Format and divisor are changed only while both engines are idle, so no property has to cover a frame whose shape changes in flight.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam logic [2:0] ADDR_ENABLE  = 3'd0;
  localparam logic [2:0] ADDR_CONTROL = 3'd1;
  localparam logic [2:0] ADDR_FORMAT  = 3'd2;
  localparam logic [2:0] ADDR_DIV_LO  = 3'd3;
  localparam logic [2:0] ADDR_DIV_HI  = 3'd4;

  localparam int CTL_RX_ON = 0;
  localparam int CTL_TX_ON = 1;
  localparam int CTL_SRST  = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic eightBit;
    logic twoStop;
    logic parEn;
    logic parOdd;
  } format_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic   engClr;
    logic   txLoad;
    logic   txShift;
    phase_e txPhase;
    logic   rxClear;
    logic   rxShift;
    logic   rxParSample;
    logic   rxDone;
  } strobe_t;

endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS_RATE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       txValid,
  input  logic       rxSync,
  output logic       txReady,
  output logic       txIdle,
  output format_t    fmt,
  output strobe_t    strb
);

  localparam int TICK_W = $clog2(OVS_RATE);
  localparam int HALF   = OVS_RATE / 2;
  localparam logic [TICK_W-1:0] SUB_LAST = TICK_W'(OVS_RATE - 1);
  localparam logic [TICK_W-1:0] SUB_MID  = TICK_W'(HALF - 1);

  logic             portEn;
  logic [2:0]       ctrlReg;
  logic [DIV_W-1:0] divReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portEn  <= 1'b0;
      ctrlReg <= '0;
      fmt     <= '{eightBit: 1'b1, twoStop: 1'b0, parEn: 1'b0, parOdd: 1'b0};
      divReg  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_ENABLE:  portEn  <= regWrData[0];
        ADDR_CONTROL: ctrlReg <= regWrData[2:0];
        ADDR_FORMAT:  fmt     <= '{eightBit: regWrData[0], twoStop: regWrData[1],
                                   parEn: regWrData[2], parOdd: regWrData[4]};
        ADDR_DIV_LO:  divReg[7:0] <= regWrData;
        ADDR_DIV_HI:  divReg[DIV_W-1:8] <= regWrData[DIV_W-9:0];
        default: ;
      endcase
    end
  end

  logic engClr, rxOn, txOn;
  assign engClr = !portEn || ctrlReg[CTL_SRST];
  assign rxOn   = !engClr && ctrlReg[CTL_RX_ON];
  assign txOn   = !engClr && ctrlReg[CTL_TX_ON];

  // shared sub-tick prescaler
  logic [DIV_W-1:0] preCnt;
  logic             tick;
  assign tick = (preCnt >= divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (engClr || tick)  preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  logic [2:0] lastIdx;
  assign lastIdx = fmt.eightBit ? 3'd7 : 3'd6;

  // transmit sequencer
  phase_e            txPh;
  logic [TICK_W-1:0] txSub;
  logic [2:0]        txIdx;
  logic              txSecond;
  logic              txBitEnd;
  assign txBitEnd = tick && (txSub == SUB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || !txOn) begin
      txPh     <= PH_IDLE;
      txSub    <= '0;
      txIdx    <= '0;
      txSecond <= 1'b0;
    end else if (txPh == PH_IDLE) begin
      if (txValid) begin
        txPh     <= PH_START;
        txSub    <= '0;
        txIdx    <= '0;
        txSecond <= 1'b0;
      end
    end else if (tick) begin
      txSub <= txBitEnd ? '0 : txSub + 1'b1;
      if (txBitEnd) begin
        case (txPh)
          PH_START: txPh <= PH_DATA;
          PH_DATA:
            if (txIdx == lastIdx) txPh <= fmt.parEn ? PH_PARITY : PH_STOP;
            else                  txIdx <= txIdx + 1'b1;
          PH_PARITY: txPh <= PH_STOP;
          PH_STOP:
            if (fmt.twoStop && !txSecond) txSecond <= 1'b1;
            else                          txPh <= PH_IDLE;
          default: txPh <= PH_IDLE;
        endcase
      end
    end
  end

  // receive sequencer
  phase_e            rxPh;
  logic [TICK_W-1:0] rxSub;
  logic [2:0]        rxIdx;
  logic              rxBitEnd;
  assign rxBitEnd = tick && (rxSub == SUB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || !rxOn) begin
      rxPh  <= PH_IDLE;
      rxSub <= '0;
      rxIdx <= '0;
    end else begin
      case (rxPh)
        PH_IDLE:
          if (!rxSync) begin
            rxPh  <= PH_START;
            rxSub <= '0;
          end
        PH_START:
          if (tick) begin
            if (rxSub == SUB_MID) begin
              rxSub <= '0;
              rxIdx <= '0;
              rxPh  <= rxSync ? PH_IDLE : PH_DATA;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
        default:
          if (tick) begin
            rxSub <= rxBitEnd ? '0 : rxSub + 1'b1;
            if (rxBitEnd) begin
              case (rxPh)
                PH_DATA:
                  if (rxIdx == lastIdx) rxPh <= fmt.parEn ? PH_PARITY : PH_STOP;
                  else                  rxIdx <= rxIdx + 1'b1;
                PH_PARITY: rxPh <= PH_STOP;
                default:   rxPh <= PH_IDLE;
              endcase
            end
          end
      endcase
    end
  end

  assign txReady = txOn && (txPh == PH_IDLE);
  assign txIdle  = (txPh == PH_IDLE);

  always_comb begin
    strb             = '0;
    strb.engClr      = engClr;
    strb.txLoad      = txReady && txValid;
    strb.txShift     = txBitEnd && (txPh == PH_DATA);
    strb.txPhase     = txPh;
    strb.rxClear     = rxOn && (rxPh == PH_IDLE) && !rxSync;
    strb.rxShift     = rxBitEnd && (rxPh == PH_DATA);
    strb.rxParSample = rxBitEnd && (rxPh == PH_PARITY);
    strb.rxDone      = rxBitEnd && (rxPh == PH_STOP);
  end

endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       eightBit,
  input  logic       parEn,
  input  logic       parOdd,
  input  logic [7:0] txData,
  input  logic       rxLine,
  input  logic       rxReady,
  output logic       txLine,
  output logic       rxSync,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic [2:0] errFlags
);

  logic [7:0] dataMask;
  assign dataMask = eightBit ? 8'hFF : 8'h7F;

  // input synchroniser, idle high
  logic [1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign rxSync = syncQ[1];

  // transmit shifter
  logic [7:0] txShiftQ;
  logic       txParQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftQ <= '0;
      txParQ   <= 1'b0;
    end else if (strb.txLoad) begin
      txShiftQ <= txData;
      txParQ   <= (^(txData & dataMask)) ^ parOdd;
    end else if (strb.txShift) begin
      txShiftQ <= txShiftQ >> 1;
    end
  end

  always_comb begin
    case (strb.txPhase)
      PH_START:  txLine = 1'b0;
      PH_DATA:   txLine = txShiftQ[0];
      PH_PARITY: txLine = txParQ;
      default:   txLine = 1'b1;
    endcase
  end

  // receive shifter and parity tracking
  logic [7:0] rxShiftQ;
  logic       rxParAcc;
  logic       rxParBad;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      rxParAcc <= 1'b0;
      rxParBad <= 1'b0;
    end else if (strb.rxClear) begin
      rxShiftQ <= '0;
      rxParAcc <= 1'b0;
      rxParBad <= 1'b0;
    end else if (strb.rxShift) begin
      rxShiftQ <= {rxSync, rxShiftQ[7:1]};
      rxParAcc <= rxParAcc ^ rxSync;
    end else if (strb.rxParSample) begin
      rxParBad <= rxSync != (rxParAcc ^ parOdd);
    end
  end

  logic [7:0] rxAssembled;
  assign rxAssembled = eightBit ? rxShiftQ : {1'b0, rxShiftQ[7:1]};

  // one-entry holding register and per-character status
  logic       holdFull;
  logic [7:0] holdData;
  logic [2:0] errQ;
  logic       canStore;
  assign canStore = !holdFull || rxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
      errQ     <= '0;
    end else if (strb.engClr) begin
      holdFull <= 1'b0;
      errQ     <= '0;
    end else if (strb.rxDone) begin
      errQ <= {!canStore, !rxSync, rxParBad && parEn};
      if (canStore) begin
        holdData <= rxAssembled;
        holdFull <= 1'b1;
      end
    end else if (holdFull && rxReady) begin
      holdFull <= 1'b0;
    end
  end

  assign rxData   = holdData;
  assign rxValid  = holdFull;
  assign errFlags = errQ;

endmodule

// File: rtl/sio_core.sv
module sio_core
  import sio_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS_RATE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       txValid,
  input  logic [7:0] txData,
  output logic       txReady,
  output logic       txLine,
  input  logic       rxLine,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  output logic [7:0] statusOut
);

  format_t    fmt;
  strobe_t    strb;
  logic       rxSync;
  logic       txIdle;
  logic [2:0] errFlags;

  sio_ctrl #(
    .DIV_W   (DIV_W),
    .OVS_RATE(OVS_RATE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .txValid  (txValid),
    .rxSync   (rxSync),
    .txReady  (txReady),
    .txIdle   (txIdle),
    .fmt      (fmt),
    .strb     (strb)
  );

  sio_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .eightBit(fmt.eightBit),
    .parEn   (fmt.parEn),
    .parOdd  (fmt.parOdd),
    .txData  (txData),
    .rxLine  (rxLine),
    .rxReady (rxReady),
    .txLine  (txLine),
    .rxSync  (rxSync),
    .rxData  (rxData),
    .rxValid (rxValid),
    .errFlags(errFlags)
  );

  // twoStop is used only by the sequencer
  assign statusOut = {1'b0, txIdle, 3'b000, errFlags};

endmodule

// File: rtl/sio_core_checker.sv
module sio_core_checker (
  input logic       clk,
  input logic       rstN,
  input logic       txLine,
  input logic       txReady,
  input logic       txIdleFlag,
  input logic       rxValid,
  input logic       rxReady,
  input logic [7:0] rxData,
  input logic [2:0] errBits,
  input logic       engOff,
  input logic       srstWrite,
  input logic       portOffWrite,
  input logic       enCtlWrite
);

  a_r10_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    txIdleFlag |-> txLine);

  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txIdleFlag);

  a_r9_overrun_has_held: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBits[2]) |-> $past(rxValid));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !engOff && !enCtlWrite) |=> (rxValid && $stable(rxData)));

  a_r12_soft_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    srstWrite |=> ##1 (txIdleFlag && txLine && !rxValid && errBits == 3'b000));

  a_r13_disable_blocks_tx: assert property (@(posedge clk) disable iff (!rstN)
    portOffWrite |=> ##1 (!txReady && txIdleFlag));

endmodule

bind sio_core sio_core_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .txLine      (txLine),
  .txReady     (txReady),
  .txIdleFlag  (statusOut[6]),
  .rxValid     (rxValid),
  .rxReady     (rxReady),
  .rxData      (rxData),
  .errBits     (statusOut[2:0]),
  .engOff      (strb.engClr),
  .srstWrite   (regWrEn && regAddr == 3'd1 && regWrData[2]),
  .portOffWrite(regWrEn && regAddr == 3'd0 && !regWrData[0]),
  .enCtlWrite  (regWrEn && (regAddr == 3'd0 || regAddr == 3'd1))
);

// File: tb/test_sio_core.sv
module test_sio_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  typedef struct packed {
    logic [7:0]  cfg;
    logic [15:0] div;
    logic [7:0]  data;
  } vec_t;

  // format bits: 0 eight-bit, 1 two stop, 2 parity on, 4 odd
  localparam vec_t VECS [0:5] = '{
    '{8'h01, 16'h0000, 8'hA5},
    '{8'h00, 16'h0001, 8'hD3},
    '{8'h05, 16'h0002, 8'h37},
    '{8'h17, 16'h0003, 8'hC8},
    '{8'h06, 16'h0000, 8'h7F},
    '{8'h14, 16'h0100, 8'h6B}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       txValid = 1'b0;
  logic [7:0] txData = '0;
  logic       txReady;
  logic       txLine;
  logic       rxLine = 1'b1;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic [7:0] statusOut;

  int checkCount = 0;
  int failCount  = 0;
  int bitLen     = 16;
  bit finished   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_core i_sio_core (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .txValid  (txValid),
    .txData   (txData),
    .txReady  (txReady),
    .txLine   (txLine),
    .rxLine   (rxLine),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .rxReady  (rxReady),
    .statusOut(statusOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic setFormat(input logic [7:0] cfg, input logic [15:0] div);
    regWrite(3'd2, cfg);
    regWrite(3'd3, div[7:0]);
    regWrite(3'd4, div[15:8]);
    bitLen = 16 * (int'(div) + 1);
  endtask

  function automatic logic [7:0] maskOf(input logic [7:0] cfg);
    return cfg[0] ? 8'hFF : 8'h7F;
  endfunction

  task automatic txFrame(input logic [7:0] d, input logic [7:0] cfg);
    logic [7:0] got;
    logic [7:0] m;
    int n;
    m = maskOf(cfg);
    n = cfg[0] ? 8 : 7;
    got = '0;
    while (!txReady) @(negedge clk);
    txData = d; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    while (txLine) @(negedge clk);
    repeat (bitLen / 2) @(negedge clk);
    chk("R2 start bit low", txLine, 1'b0);
    chk("R10 busy while sending", statusOut[6], 1'b0);
    for (int i = 0; i < n; i++) begin
      repeat (bitLen) @(negedge clk);
      got[i] = txLine;
    end
    chk("R2 R5 tx data lsb first", got, d & m);
    if (cfg[2]) begin
      repeat (bitLen) @(negedge clk);
      chk("R4 tx parity bit", txLine, (^(d & m)) ^ cfg[4]);
    end
    repeat (bitLen) @(negedge clk);
    chk("R3 first stop high", txLine, 1'b1);
    repeat (bitLen) @(negedge clk);
    chk("R3 stop count via idle flag", statusOut[6], !cfg[1]);
    chk("R10 line high after first stop", txLine, 1'b1);
  endtask

  task automatic rxFrame(input logic [7:0] d, input logic [7:0] cfg,
                         input bit flipPar, input bit stopLow);
    logic [7:0] m;
    int n;
    m = maskOf(cfg);
    n = cfg[0] ? 8 : 7;
    rxLine = 1'b0;
    repeat (bitLen) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxLine = d[i];
      repeat (bitLen) @(negedge clk);
    end
    if (cfg[2]) begin
      rxLine = (^(d & m)) ^ cfg[4] ^ flipPar;
      repeat (bitLen) @(negedge clk);
    end
    if (stopLow) begin
      rxLine = 1'b0;
      repeat (bitLen * 3 / 4) @(negedge clk);
      rxLine = 1'b1;
      repeat (bitLen - bitLen * 3 / 4) @(negedge clk);
    end else begin
      rxLine = 1'b1;
      repeat (bitLen) @(negedge clk);
    end
    if (cfg[1]) repeat (bitLen) @(negedge clk);
    repeat (bitLen) @(negedge clk);
  endtask

  task automatic rxTake();
    @(negedge clk);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
    finish();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R13: reset state
    chk("R1 R10 reset status", statusOut, 8'h40);
    chk("R13 reset txReady low", txReady, 1'b0);
    chk("R1 reset line high", txLine, 1'b1);
    chk("R1 reset rxValid low", rxValid, 1'b0);

    regWrite(3'd0, 8'h01);
    regWrite(3'd1, 8'h03);
    chk("R11 tx ready once enabled", txReady, 1'b1);
    // R1: default format is 8N1 with divisor 0 (bitLen 16)
    txFrame(8'h5C, 8'h01);

    for (int v = 0; v < 6; v++) begin
      setFormat(VECS[v].cfg, VECS[v].div);
      txFrame(VECS[v].data, VECS[v].cfg);
      rxFrame(VECS[v].data, VECS[v].cfg, 1'b0, 1'b0);
      chk("R11 rx character delivered", rxValid, 1'b1);
      chk("R2 R5 rx data", rxData, VECS[v].data & maskOf(VECS[v].cfg));
      chk("R14 clean character status", statusOut[2:0], 3'b000);
      rxTake();
      chk("R9 holding register emptied", rxValid, 1'b0);
    end

    // R7 parity error, R14 cleared by a clean character
    setFormat(8'h05, 16'h0000);
    rxFrame(8'h96, 8'h05, 1'b1, 1'b0);
    chk("R7 parity error flag", statusOut[2:0], 3'b001);
    chk("R7 data still delivered", rxData, 8'h96);
    rxTake();
    rxFrame(8'h4E, 8'h05, 1'b0, 1'b0);
    chk("R14 clean char clears flags", statusOut[2:0], 3'b000);
    rxTake();

    // R8 framing error
    setFormat(8'h01, 16'h0000);
    rxFrame(8'h21, 8'h01, 1'b0, 1'b1);
    chk("R8 framing error flag", statusOut[2:0], 3'b010);
    chk("R8 data still delivered", rxData, 8'h21);
    rxTake();

    // R9 overrun: second character dropped
    rxFrame(8'hE1, 8'h01, 1'b0, 1'b0);
    rxFrame(8'h1E, 8'h01, 1'b0, 1'b0);
    chk("R9 overrun flag", statusOut[2:0], 3'b100);
    chk("R9 first char kept", rxData, 8'hE1);
    chk("R9 still valid", rxValid, 1'b1);

    // R12 soft reset mid-frame with a held char and overrun flag
    setFormat(8'h01, 16'h0003);
    @(negedge clk);
    txData = 8'h00; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    repeat (3 * bitLen) @(negedge clk);
    chk("R12 line low before reset", txLine, 1'b0);
    regWrite(3'd1, 8'h07);
    chk("R12 line back high", txLine, 1'b1);
    chk("R12 status cleared and idle", statusOut, 8'h40);
    chk("R12 holding emptied", rxValid, 1'b0);
    chk("R12 txReady low while held", txReady, 1'b0);
    regWrite(3'd1, 8'h03);
    chk("R12 released ready", txReady, 1'b1);

    // R6 glitch rejection
    rxLine = 1'b0;
    repeat (bitLen / 4) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * bitLen) @(negedge clk);
    chk("R6 glitch yields no char", rxValid, 1'b0);
    rxFrame(8'h3C, 8'h01, 1'b0, 1'b0);
    chk("R6 next frame accepted", rxData, 8'h3C);
    chk("R6 next frame valid", rxValid, 1'b1);
    rxTake();

    // R11 receiver off, transmitter off
    regWrite(3'd1, 8'h02);
    rxFrame(8'h55, 8'h01, 1'b0, 1'b0);
    chk("R11 rx disabled no char", rxValid, 1'b0);
    chk("R11 tx still ready", txReady, 1'b1);
    regWrite(3'd1, 8'h01);
    chk("R11 tx disabled not ready", txReady, 1'b0);
    regWrite(3'd1, 8'h03);

    // R13 port enable gate
    regWrite(3'd0, 8'h00);
    chk("R13 disabled not ready", txReady, 1'b0);
    chk("R13 disabled idle flag", statusOut[6], 1'b1);
    rxFrame(8'hAA, 8'h01, 1'b0, 1'b0);
    chk("R13 disabled no rx", rxValid, 1'b0);
    regWrite(3'd0, 8'h01);
    chk("R13 re-enabled ready", txReady, 1'b1);

    finish();
  end

endmodule